// File: doc/BRIEF.md
# Windowed-Compare System Timer

A free-running 56-bit timer with two independent compare channels. Each channel picks a contiguous slice of timer bits, set by a start position and a width. It compares that slice with the same number of low-order bits of the channel's own 32-bit compare value. When the slice becomes equal to the compare value, the channel records a match in a sticky status flag. The flag, gated by a per-channel enable, drives that channel's interrupt request output.

Software programs the block through a small word-addressed register interface. Writes are synchronous. Reads are combinational from the current address. Through this interface it presets the timer, loads the compare values and the window fields, sets the interrupt enables, and clears status flags. A channel set to a width of one bit, with start position n, flags every rising edge of timer bit n. The timer advances by one on each cycle where `tick_en` is high.

Register addresses: 0 = timer bits 31:0, 1 = timer bits 55:32 (in data bits 23:0), 2 = channel 0 compare, 3 = channel 1 compare, 4 = window fields, 5 = interrupt enables, 6 = status. In the window register, channel c uses bits 16c+4..16c for its size field and bits 16c+12..16c+8 for its start field.

Top module: `wintimer`

## Requirements
- R1: Reset clears the timer to 0. The timer adds one on each clock with `tick_en` high, holds its value when `tick_en` is low, and wraps from all ones to 0.
- R2: A write to address 0 loads timer bits 31:0. A write to address 1 loads timer bits 55:32 from write data bits 23:0. A load takes precedence over the increment in the same cycle. Reads of addresses 0 and 1 return the same bit fields, with zeros above bit 23 on address 1.
- R3: With size field s and start field p, a channel compares timer bits p+s..p with compare-value bits s..0. Compare-value bits above bit s have no effect.
- R4: A channel raises a match event only in the cycle where its equality goes from false to true. Equality that stays true produces no further event. Right after reset, a channel raises no event until its equality has first been false.
- R5: A match event sets that channel's status bit (address 6, bit c) at the next clock edge. The bit stays set until software writes 1 to it. If a match event and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: Interrupt output `irq[c]` is high exactly when status bit c and enable bit c (address 5, bit c) are both set.
- R7: A start field written above 24 is stored as 24. The window register reads back the stored fields.
- R8: The two channels are independent: each uses only its own compare value, size and start fields.
- R9: The compare values and the enable bits read back at their addresses as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer advances by one while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` (combinational) |
| irq | output | 2 | Interrupt request per channel |

## Verification
A register write takes effect at the clock edge that samples it. Timer reads after that edge show the new value, and status reads and `irq` follow the enable or clear at that same edge. The timer reaches the compare target at some edge. The status bit and `irq` rise one edge later, because the match event is registered into the status flag. The directed tasks therefore preset the timer a few counts below each target and then advance one cycle at a time. At each falling edge they expect the interrupt only once the previous count had reached the target, which confirms the match lands on exactly the expected count. All inputs change and all outputs are sampled at falling edges, with a short settling delay before combinational reads.

// File: rtl/wintimer_pkg.sv
package wintimer_pkg;

    localparam int CNT_W     = 56;
    localparam int CMP_W     = 32;
    localparam int DATA_W    = 32;
    localparam int NCH       = 2;
    localparam int FLD_W     = 5;
    localparam int START_MAX = 24;
    localparam int ADDR_W    = 3;
    localparam int HI_W      = CNT_W - DATA_W;
    localparam int CH_STRIDE = 16;
    localparam int START_OFS = 8;

    localparam logic [ADDR_W-1:0] A_TLO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_THI  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_WIN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd5;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd6;

    typedef struct packed {
        logic [FLD_W-1:0] start;
        logic [FLD_W-1:0] size;
    } win_t;

    function automatic logic [CMP_W-1:0] width_mask(input logic [FLD_W-1:0] sz);
        logic [CMP_W-1:0] m;
        for (int i = 0; i < CMP_W; i++) begin
            m[i] = (i <= int'(sz));
        end
        return m;
    endfunction

    function automatic logic [FLD_W-1:0] clamp_start(input logic [FLD_W-1:0] s);
        return (int'(s) > START_MAX) ? FLD_W'(START_MAX) : s;
    endfunction

    function automatic logic [CMP_W-1:0] window_bits(input logic [CNT_W-1:0] cnt,
                                                     input win_t w);
        logic [CNT_W-1:0] sh;
        sh = cnt >> w.start;
        return sh[CMP_W-1:0] & width_mask(w.size);
    endfunction

endpackage

// File: rtl/wt_counter.sv
module wt_counter
    import wintimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [DATA_W-1:0] lo_data,
    input  logic [HI_W-1:0]   hi_data,
    output logic [CNT_W-1:0]  cnt
);
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = cnt;
        if (ld_lo) load_val[DATA_W-1:0] = lo_data;
        if (ld_hi) load_val[CNT_W-1:DATA_W] = hi_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld_lo || ld_hi) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wt_channel.sv
module wt_channel
    import wintimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CMP_W-1:0] cmp,
    input  win_t             win,
    output logic             eq,
    output logic             evt
);
    logic eq_q;

    always_comb begin
        eq  = (window_bits(cnt, win) == (cmp & width_mask(win.size)));
        evt = eq && !eq_q;
    end

    // Previous-equality flag resets high so reset itself is not a rising edge.
    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b1;
        else     eq_q <= eq;
    end
endmodule

// File: rtl/wt_regs.sv
module wt_regs
    import wintimer_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NCH-1:0]           evt,
    input  logic [CNT_W-1:0]         cnt,
    output logic [NCH-1:0][CMP_W-1:0] cmp,
    output win_t [NCH-1:0]           win,
    output logic [NCH-1:0]           en,
    output logic [NCH-1:0]           status,
    output logic [DATA_W-1:0]        rdata
);
    logic [NCH-1:0] clr;
    logic [DATA_W-1:0] win_word;

    always_comb begin
        clr = (wr_en && addr == A_STAT) ? wdata[NCH-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= '0;
            status <= '0;
        end else begin
            if (wr_en && addr == A_EN) en <= wdata[NCH-1:0];
            // set has priority over clear
            status <= (status & ~clr) | evt;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp[c] <= '0;
                win[c] <= '0;
            end else begin
                if (wr_en && int'(addr) == int'(A_CMP0) + c) cmp[c] <= wdata;
                if (wr_en && addr == A_WIN) begin
                    win[c].size  <= wdata[c*CH_STRIDE +: FLD_W];
                    win[c].start <= clamp_start(wdata[c*CH_STRIDE + START_OFS +: FLD_W]);
                end
            end
        end
    end

    always_comb begin
        win_word = '0;
        for (int c = 0; c < NCH; c++) begin
            win_word[c*CH_STRIDE +: FLD_W]             = win[c].size;
            win_word[c*CH_STRIDE + START_OFS +: FLD_W] = win[c].start;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_TLO:  rdata = cnt[DATA_W-1:0];
            A_THI:  rdata = DATA_W'(cnt[CNT_W-1:DATA_W]);
            A_WIN:  rdata = win_word;
            A_EN:   rdata = DATA_W'(en);
            A_STAT: rdata = DATA_W'(status);
            default: begin
                for (int c = 0; c < NCH; c++) begin
                    if (int'(addr) == int'(A_CMP0) + c) rdata = cmp[c];
                end
            end
        endcase
    end
endmodule

// File: rtl/wintimer.sv
module wintimer
    import wintimer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [1:0]  irq
);
    logic [CNT_W-1:0]          cnt_q;
    logic [NCH-1:0][CMP_W-1:0] cmp_q;
    win_t [NCH-1:0]            win_q;
    logic [NCH-1:0]            en_q;
    logic [NCH-1:0]            status_q;
    logic [NCH-1:0]            ch_eq;
    logic [NCH-1:0]            ch_evt;
    logic [NCH-1:0][FLD_W-1:0] start_f;

    wt_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .ld_lo   (wr_en && addr == A_TLO),
        .ld_hi   (wr_en && addr == A_THI),
        .lo_data (wdata),
        .hi_data (wdata[HI_W-1:0]),
        .cnt     (cnt_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        wt_channel u_ch (
            .clk (clk),
            .rst (rst),
            .cnt (cnt_q),
            .cmp (cmp_q[c]),
            .win (win_q[c]),
            .eq  (ch_eq[c]),
            .evt (ch_evt[c])
        );
        assign start_f[c] = win_q[c].start;
    end

    wt_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .evt    (ch_evt),
        .cnt    (cnt_q),
        .cmp    (cmp_q),
        .win    (win_q),
        .en     (en_q),
        .status (status_q),
        .rdata  (rdata)
    );

    assign irq = status_q & en_q;
endmodule

// File: rtl/wintimer_chk.sv
module wintimer_chk
    import wintimer_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     tick_en,
    input logic                     wr_en,
    input logic [ADDR_W-1:0]        addr,
    input logic [DATA_W-1:0]        wdata,
    input logic [CNT_W-1:0]         cnt,
    input logic [NCH-1:0]           status,
    input logic [NCH-1:0]           eq,
    input logic [NCH-1:0][FLD_W-1:0] start_f
);
    logic loading;
    assign loading = wr_en && (addr == A_TLO || addr == A_THI);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !loading) |=> (cnt == $past(cnt) + CNT_W'(1))); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !loading) |=> $stable(cnt)); // R1
    AST_LOAD_LO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_TLO) |=> (cnt[DATA_W-1:0] == $past(wdata))); // R2

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !(wr_en && addr == A_STAT && wdata[i])) |=> status[i]); // R5
        AST_SET_NEEDS_EQ: assert property (@(posedge clk) disable iff (rst)
            $rose(status[i]) |-> $past(eq[i])); // R4
        AST_HELD_EQ_QUIET: assert property (@(posedge clk) disable iff (rst)
            (eq[i] && $past(eq[i]) && !status[i]) |=> !status[i]); // R4
        AST_START_LIMIT: assert property (@(posedge clk) disable iff (rst)
            int'(start_f[i]) <= START_MAX); // R7
    end
endmodule

bind wintimer wintimer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt     (cnt_q),
    .status  (status_q),
    .eq      (ch_eq),
    .start_f (start_f)
);

// File: tb/wintimer_tb.sv
module wintimer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    logic [31:0] win_shadow = '0;

    wintimer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got %0d cycles exp below %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_win(input int ch, input logic [4:0] sz, input logic [4:0] st);
        win_shadow[ch*16 +: 5]     = sz;
        win_shadow[ch*16 + 8 +: 5] = st;
        wr(3'd4, win_shadow);
    endtask

    task automatic load_timer(input logic [55:0] v);
        wr(3'd0, v[31:0]);
        wr(3'd1, {8'h0, v[55:32]});
    endtask

    // Preset timer PRE counts below target, then step and check irq each cycle.
    task automatic run_match(input string req, input int ch, input logic [4:0] sz,
                             input logic [4:0] st, input logic [31:0] cmpv,
                             input logic [55:0] target, input int pre);
        logic [55:0] base;
        tick_en = 1'b0;
        base = target - 56'(pre);
        set_win(ch, sz, st);
        wr(3'(2 + ch), cmpv);
        wr(3'd5, 32'h3);
        load_timer(base);
        wr(3'd6, 32'h3);
        check({req, " irq clear before run"}, 64'(irq[ch]), 64'd0);
        tick_en = 1'b1;
        for (int k = 1; k <= pre + 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            check({req, " irq at count"}, 64'(irq[ch]),
                  64'((base + 56'(k) - 56'd1) >= target));
        end
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); check("R1 reset timer lo", 64'(d), 64'd0);
        rd(3'd6, d); check("R5 reset status", 64'(d), 64'd0);
        check("R6 reset irq", 64'(irq), 64'd0);
        repeat (3) @(negedge clk);
        rd(3'd0, d); check("R1 hold without tick", 64'(d), 64'd0);
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        rd(3'd0, d); check("R1 increments", 64'(d), 64'd3);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        tick_en = 1'b0;
        load_timer(56'hFF_FFFF_FFFF_FFFF);
        rd(3'd1, d); check("R2 hi readback", 64'(d), 64'h00FF_FFFF);
        rd(3'd0, d); check("R2 lo readback", 64'(d), 64'hFFFF_FFFF);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        rd(3'd0, d); check("R1 wrap lo", 64'(d), 64'd0);
        rd(3'd1, d); check("R1 wrap hi", 64'(d), 64'd0);
        // load beats increment in the same cycle
        tick_en = 1'b1;
        wr(3'd0, 32'h0000_1000);
        tick_en = 1'b0;
        rd(3'd0, d); check("R2 load over tick", 64'(d), 64'h1000);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(3'd2, 32'hDEAD_BEEF);
        wr(3'd3, 32'h1234_5678);
        rd(3'd2, d); check("R9 cmp0 readback", 64'(d), 64'hDEAD_BEEF);
        rd(3'd3, d); check("R9 cmp1 readback", 64'(d), 64'h1234_5678);
        wr(3'd5, 32'h2);
        rd(3'd5, d); check("R9 enable readback", 64'(d), 64'h2);
        set_win(0, 5'd3, 5'd31);
        rd(3'd4, d); check("R7 start saturates", 64'(d[12:8]), 64'd24);
        check("R7 size kept", 64'(d[4:0]), 64'd3);
    endtask

    task automatic t_edge_only();
        logic [31:0] d;
        // size 7 start 7: bits 14:7 against 0xA5; junk above bit 7 ignored (R3)
        run_match("R3 R8 ch1 size7 start7", 1, 5'd7, 5'd7, 32'hFFFF_FFA5,
                  56'(32'hA5) << 7, 4);
        tick_en = 1'b1;
        wr(3'd6, 32'h2);
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd(3'd6, d); check("R4 no event while held equal", 64'(d[1]), 64'd0);
        check("R4 irq stays low", 64'(irq[1]), 64'd0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        run_match("R3 ch0 size17 start10", 0, 5'd17, 5'd10, 32'hFFFC_0000 | 32'h2_1357,
                  56'(32'h2_1357) << 10, 5);
        wr(3'd5, 32'h2);
        check("R6 irq masked", 64'(irq[0]), 64'd0);
        rd(3'd6, d); check("R6 status kept while masked", 64'(d[0]), 64'd1);
        wr(3'd5, 32'h3);
        check("R6 irq unmasked", 64'(irq[0]), 64'd1);
        wr(3'd6, 32'h1);
        check("R5 clear by write 1", 64'(irq[0]), 64'd0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        tick_en = 1'b0;
        set_win(0, 5'd0, 5'd5);
        wr(3'd2, 32'h1);
        load_timer(56'h0);
        wr(3'd6, 32'h3);
        wr(3'd0, 32'h20);          // bit 5 rises: event pending this cycle
        wr(3'd6, 32'h1);           // clear collides with event
        rd(3'd6, d); check("R5 set wins over clear", 64'(d[0]), 64'd1);
        wr(3'd6, 32'h1);
        rd(3'd6, d); check("R5 later clear works", 64'(d[0]), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wrap();
        t_regs();
        t_edge_only();
        t_enable();
        // single-bit: bit 24 rising
        run_match("R3 single bit 24", 0, 5'd0, 5'd24, 32'h1, 56'h100_0000, 3);
        // full 32-bit window from bit 24, needs upper timer bits
        run_match("R2 R3 window 55:24", 0, 5'd31, 5'd24, 32'h123,
                  56'h123 << 24, 3);
        t_set_wins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule